// File: doc/BRIEF.md
# Pointer Register Literal Arithmetic Unit

This block carries out a small group of single-word instructions that work on three 12-bit data-memory pointers. Each instruction either adds a short unsigned literal to a chosen pointer, subtracts one from it, or pushes an 8-bit literal onto a software stack that grows toward lower addresses through pointer 2. One form of add and subtract also asks the core to return from the current subroutine once the pointer has moved. None of these instructions touch any status flag.

The core presents a 16-bit instruction word with a one-cycle valid strobe. A configuration enable input gates the whole group: with it low, the opcodes do nothing. The pointer values appear on three output buses. A push drives a one-cycle byte write toward data memory. A return variant drives a one-cycle return request to the core.

Top module: `ptr_lit_unit`

## Requirements
- R1: After reset, all three pointers read 0x000, and mem_we and ret_req are low.
- R2: Opcode byte 0xE8 (instr_word[15:8]) adds the zero-extended literal instr_word[5:0] to the pointer selected by instr_word[7:6] (00, 01, 10 pick pointer 0, 1, 2). The result is visible in the cycle after acceptance, and the other pointers are unchanged.
- R3: Opcode byte 0xE9 subtracts the zero-extended literal instr_word[5:0] from the pointer selected by instr_word[7:6], with the same field layout and timing as R2.
- R4: With select value 11, opcode 0xE8 or 0xE9 acts on pointer 2. ret_req is then high for exactly the one cycle after acceptance, the same cycle in which the updated pointer 2 first shows.
- R5: An instruction presented during the cycle in which ret_req is high is ignored. No pointer changes, no write and no return request result from it.
- R6: Opcode byte 0xEA in the cycle after acceptance drives mem_we high for one cycle, with mem_addr equal to the old pointer 2 and mem_wdata equal to instr_word[7:0]. Pointer 2 then reads one less than before.
- R7: While ext_en is low, the opcodes 0xE8, 0xE9 and 0xEA cause no pointer change, no write and no return request.
- R8: Any other opcode byte, or any word with instr_valid low, has no effect.
- R9: All pointer arithmetic wraps modulo 2^12. 0xFFD + 3 gives 0x000, 0x002 - 5 gives 0xFFD, and a push with pointer 2 at 0x000 leaves it at 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Configuration enable for the instruction group |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| ptr0 | output | 12 | Pointer 0 value |
| ptr1 | output | 12 | Pointer 1 value |
| ptr2 | output | 12 | Pointer 2 value, software stack pointer |
| mem_we | output | 1 | Data-memory byte write enable |
| mem_addr | output | 12 | Data-memory write address |
| mem_wdata | output | 8 | Data-memory write byte |
| ret_req | output | 1 | One-cycle subroutine return request |

## Verification
The hardest case to reach is a word that arrives during the second cycle of a return variant. A core that keeps to the two-cycle count would never send one, yet the block must drop it. The bench reaches this case on purpose: it accepts an add-and-return, then at the following falling edge raises the strobe again with an add to pointer 0. It then checks that pointer 0 has not moved and that no second return pulse appears, and afterwards that the same word is taken normally once the return cycle has passed. The wrap cases are reached by running pointers below zero through the stimulus table and then pushing with pointer 2 at zero.

// File: rtl/ptr_lit_pkg.sv
package ptr_lit_pkg;

    localparam int unsigned OPC_W   = 8;
    localparam int unsigned LIT_W   = 8;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned NUM_PTR = 3;

    localparam logic [OPC_W-1:0] OPC_ADD  = 8'hE8;
    localparam logic [OPC_W-1:0] OPC_SUB  = 8'hE9;
    localparam logic [OPC_W-1:0] OPC_PUSH = 8'hEA;

    localparam logic [SEL_W-1:0] SEL_RET   = 2'b11;
    localparam logic [SEL_W-1:0] SEL_STACK = 2'b10;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_PUSH = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [SEL_W-1:0] sel;
        logic             ret;
        logic [LIT_W-1:0] lit;
    } dec_t;

endpackage

// File: rtl/plu_decode.sv
module plu_decode
    import ptr_lit_pkg::*;
(
    input  logic        ext_en,
    input  logic        instr_valid,
    input  logic [15:0] instr_word,
    input  logic        hold,
    output dec_t        dec,
    output logic        fire
);

    logic [OPC_W-1:0] opc;
    logic [SEL_W-1:0] raw_sel;

    assign opc     = instr_word[15:8];
    assign raw_sel = instr_word[7:6];

    always_comb begin
        dec = '0;
        unique case (opc)
            OPC_ADD: begin
                dec.op  = OP_ADD;
                dec.ret = (raw_sel == SEL_RET);
                dec.sel = dec.ret ? SEL_STACK : raw_sel;
                dec.lit = {2'b00, instr_word[5:0]};
            end
            OPC_SUB: begin
                dec.op  = OP_SUB;
                dec.ret = (raw_sel == SEL_RET);
                dec.sel = dec.ret ? SEL_STACK : raw_sel;
                dec.lit = {2'b00, instr_word[5:0]};
            end
            OPC_PUSH: begin
                dec.op  = OP_PUSH;
                dec.sel = SEL_STACK;
                dec.lit = instr_word[7:0];
            end
            default: dec.op = OP_NONE;
        endcase
    end

    assign fire = instr_valid && ext_en && !hold && (dec.op != OP_NONE);

    // R4
    always_comb begin
        if (fire && dec.ret) begin
            ret_target_chk: assert (dec.sel == SEL_STACK && dec.op != OP_PUSH);
        end
    end

endmodule

// File: rtl/plu_ptr_slot.sv
module plu_ptr_slot
    import ptr_lit_pkg::*;
#(
    parameter int unsigned PTR_W = 12,
    parameter int unsigned IDX   = 0
) (
    input  logic [PTR_W-1:0] cur,
    input  dec_t             dec,
    input  logic             fire,
    output logic [PTR_W-1:0] nxt
);

    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

    logic [PTR_W-1:0] lit_ext;
    logic             hit;

    assign lit_ext = {{(PTR_W-LIT_W){1'b0}}, dec.lit};
    assign hit     = fire && (dec.sel == MY_SEL);

    always_comb begin
        nxt = cur;
        if (hit) begin
            unique case (dec.op)
                OP_ADD:  nxt = cur + lit_ext;
                OP_SUB:  nxt = cur - lit_ext;
                OP_PUSH: nxt = cur - PTR_W'(1);
                default: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/ptr_lit_unit.sv
module ptr_lit_unit
    import ptr_lit_pkg::*;
#(
    parameter int unsigned PTR_W   = 12,
    parameter logic [11:0] PTR_RST = 12'h000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic             instr_valid,
    input  logic [15:0]      instr_word,
    output logic [PTR_W-1:0] ptr0,
    output logic [PTR_W-1:0] ptr1,
    output logic [PTR_W-1:0] ptr2,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_addr,
    output logic [LIT_W-1:0] mem_wdata,
    output logic             ret_req
);

    localparam int unsigned STACK_IDX = 2;

    typedef struct packed {
        logic [NUM_PTR-1:0][PTR_W-1:0] ptr;
        logic                          we;
        logic [PTR_W-1:0]              addr;
        logic [LIT_W-1:0]              wdata;
        logic                          ret;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;
    logic   fire;
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_nxt;

    plu_decode i_decode (
        .ext_en      (ext_en),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .hold        (st_q.ret),
        .dec         (dec),
        .fire        (fire)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
        plu_ptr_slot #(
            .PTR_W (PTR_W),
            .IDX   (g)
        ) i_slot (
            .cur  (st_q.ptr[g]),
            .dec  (dec),
            .fire (fire),
            .nxt  (ptr_nxt[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.ptr = ptr_nxt;
        st_d.we  = 1'b0;
        st_d.ret = 1'b0;
        if (fire && dec.op == OP_PUSH) begin
            st_d.we    = 1'b1;
            st_d.addr  = st_q.ptr[STACK_IDX];
            st_d.wdata = dec.lit;
        end
        if (fire && dec.ret) begin
            st_d.ret = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PTR; i++) st_q.ptr[i] <= PTR_W'(PTR_RST);
            st_q.we    <= 1'b0;
            st_q.addr  <= '0;
            st_q.wdata <= '0;
            st_q.ret   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr0      = st_q.ptr[0];
    assign ptr1      = st_q.ptr[1];
    assign ptr2      = st_q.ptr[STACK_IDX];
    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign ret_req   = st_q.ret;

    // R4
    ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |=> !ret_req);

    // R5
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |=> ({ptr0, ptr1, ptr2} == $past({ptr0, ptr1, ptr2})) && !mem_we);

    // R6
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ptr2 == mem_addr - PTR_W'(1)) && !ret_req);

    // R7
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> ({ptr0, ptr1, ptr2} == $past({ptr0, ptr1, ptr2})) && !mem_we && !ret_req);

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !mem_we && !ret_req && $stable({ptr0, ptr1, ptr2}));

endmodule

// File: tb/test_ptr_lit_unit.sv
module test_ptr_lit_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic [11:0] ptr0, ptr1, ptr2, mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, ret_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ptr_lit_unit i_ptr_lit_unit (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
        .instr_valid(instr_valid), .instr_word(instr_word),
        .ptr0(ptr0), .ptr1(ptr1), .ptr2(ptr2),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ret_req(ret_req)
    );

    // {req[78:75], en[74], instr[73:58], p0, p1, p2, we[21], addr[20:9], data[8:1], ret[0]}
    localparam int NV = 16;
    localparam logic [78:0] VEC [NV] = '{
        {4'd2, 1'b1, 16'hE805, 12'h005, 12'h000, 12'h000, 1'b0, 12'h000, 8'h00, 1'b0}, // R2 ptr0
        {4'd2, 1'b1, 16'hE87F, 12'h005, 12'h03F, 12'h000, 1'b0, 12'h000, 8'h00, 1'b0}, // R2 ptr1 max k
        {4'd2, 1'b1, 16'hE8AA, 12'h005, 12'h03F, 12'h02A, 1'b0, 12'h000, 8'h00, 1'b0}, // R2 ptr2
        {4'd3, 1'b1, 16'hE903, 12'h002, 12'h03F, 12'h02A, 1'b0, 12'h000, 8'h00, 1'b0}, // R3
        {4'd9, 1'b1, 16'hE905, 12'hFFD, 12'h03F, 12'h02A, 1'b0, 12'h000, 8'h00, 1'b0}, // R9 below zero
        {4'd2, 1'b1, 16'hE843, 12'hFFD, 12'h042, 12'h02A, 1'b0, 12'h000, 8'h00, 1'b0}, // R2
        {4'd6, 1'b1, 16'hEA5A, 12'hFFD, 12'h042, 12'h029, 1'b1, 12'h02A, 8'h5A, 1'b0}, // R6 push
        {4'd4, 1'b1, 16'hE8C4, 12'hFFD, 12'h042, 12'h02D, 1'b0, 12'h000, 8'h00, 1'b1}, // R4 add+ret
        {4'd4, 1'b1, 16'hE9C1, 12'hFFD, 12'h042, 12'h02C, 1'b0, 12'h000, 8'h00, 1'b1}, // R4 sub+ret
        {4'd7, 1'b0, 16'hE810, 12'hFFD, 12'h042, 12'h02C, 1'b0, 12'h000, 8'h00, 1'b0}, // R7 add off
        {4'd7, 1'b0, 16'hEA11, 12'hFFD, 12'h042, 12'h02C, 1'b0, 12'h000, 8'h00, 1'b0}, // R7 push off
        {4'd8, 1'b1, 16'hF000, 12'hFFD, 12'h042, 12'h02C, 1'b0, 12'h000, 8'h00, 1'b0}, // R8 other
        {4'd9, 1'b1, 16'hE803, 12'h000, 12'h042, 12'h02C, 1'b0, 12'h000, 8'h00, 1'b0}, // R9 over top
        {4'd4, 1'b1, 16'hE9EC, 12'h000, 12'h042, 12'h000, 1'b0, 12'h000, 8'h00, 1'b1}, // R4 to zero
        {4'd9, 1'b1, 16'hEAFF, 12'h000, 12'h042, 12'hFFF, 1'b1, 12'h000, 8'hFF, 1'b0}, // R9 push at 0
        {4'd2, 1'b1, 16'hE87F, 12'h000, 12'h081, 12'hFFF, 1'b0, 12'h000, 8'h00, 1'b0}  // R2
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic en, input logic [15:0] w);
        @(negedge clk);
        ext_en      = en;
        instr_valid = 1'b1;
        instr_word  = w;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {ptr0, ptr1, ptr2, mem_we, ret_req}, {12'h000, 12'h000, 12'h000, 2'b00});
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [78:0] e;
            string tag;
            e = VEC[v];
            tag = $sformatf("R%0d vec%0d", e[78:75], v);
            issue(e[74], e[73:58]);
            check(tag, {ptr0, ptr1, ptr2}, {e[57:46], e[45:34], e[33:22]});
            check(tag, {mem_we, ret_req}, {e[21], e[0]});
            if (e[21]) check(tag, {mem_addr, mem_wdata}, {e[20:9], e[8:1]});
            @(negedge clk);
            // R4 R6 pulses last one cycle
            check("R4 R6 pulse end", {mem_we, ret_req}, 2'b00);
        end

        // R5: word during the return cycle is dropped
        issue(1'b1, 16'hE8C1);
        check("R4 ret", {ptr2, ret_req}, {12'h000, 1'b1});
        instr_valid = 1'b1;
        instr_word  = 16'hE805;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        check("R5 ignored", {ptr0, ret_req, mem_we}, {12'h000, 2'b00});
        issue(1'b1, 16'hE805);
        check("R5 later taken", ptr0, 12'h005);

        // R8: valid low with a live opcode
        @(negedge clk);
        ext_en = 1'b1;
        instr_word = 16'hEA33;
        @(posedge clk);
        @(negedge clk);
        check("R8 no strobe", {ptr2, mem_we}, {12'h000, 1'b0});

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 rereset", {ptr0, ptr1, ptr2, mem_we, ret_req}, {36'h0, 2'b00});
        rst_n = 1'b1;
        finish_run();
    end

endmodule